// File: doc/BRIEF.md
# Reconfigurable Dual-Operation MAC Array

The block is a row of identical arithmetic cells that a small sequencer steps through a repeating three-phase loop. Each cell keeps a permanent part: two input ports and two result registers. It also has a reconfigurable part: two source selectors, a 16-bit constant, and two operation codes. In the first phase the reconfigurable part of every cell is refreshed from a per-cell shadow word. In the second phase each cell fetches two operands from the second result register of the cells its selectors name. In the third phase each cell computes a first result from its two ports. In that same phase it combines the fresh first result with its constant to form the second result.

Software fills the shadow words at any time through the configuration port. It seeds the second result registers through the load port while the array is idle. It then issues a start pulse with a step count. The array runs that many loops and raises a one-cycle done flag. Results are read back combinationally by cell index. A 16-bit value is treated either as a plain word (bitwise AND) or as a complex pair: the real part in bits 15:8 and the imaginary part in bits 7:0, each a signed Q1.7 number.

Top module: `mac_array_reconf`

## Requirements
- R1: After reset the phase output is 0 (idle), done is low, and every result register, port, shadow word and active configuration reads 0.
- R2: A start pulse seen while idle with a nonzero step count moves the phase output to 1 (load configuration), then 2 (route), then 3 (execute), one cycle each. The loop repeats for the given number of steps and then returns to 0. A start pulse with step count 0, or one that arrives while a run is in progress, is ignored.
- R3: The done output is high for exactly one cycle. That cycle directly follows the execute phase of the last step.
- R4: The configuration word is laid out as {src1[25:23], src2[22:20], opA[19:18], opB[17:16], const[15:0]}. A write stores it in the cell's shadow word in any phase. Shadow words become active only in a load-configuration phase. A write landing in the same cycle as a load-configuration phase takes effect at the following one.
- R5: In the route phase, port1 of every cell takes reg2 of cell src1 and port2 takes reg2 of cell src2. All cells read values from before the phase.
- R6: In the execute phase reg1 takes opA(port1, port2).
- R7: In the same execute phase reg2 takes opB(new reg1, const).
- R8: Operation codes: 0 = complex add, each 8-bit part wrapping. 1 = complex multiply in Q1.7, where each part is (sum of products) arithmetically shifted right by 7 and truncated to 8 bits. 2 = bitwise AND. 3 = pass the first operand.
- R9: Configuration writes and configuration loads leave reg1 and reg2 unchanged.
- R10: A data load while idle writes reg2 of the addressed cell. A data load during a run is ignored.
- R11: rd_reg1 and rd_reg2 show reg1 and reg2 of the cell selected by rd_idx in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | 3 | Cell whose shadow word is written |
| cfg_word | input | 26 | Configuration word |
| ld_we | input | 1 | Data load strobe (idle only) |
| ld_idx | input | 3 | Cell whose reg2 is loaded |
| ld_data | input | 16 | Load value |
| start | input | 1 | Start pulse |
| steps | input | 4 | Number of loops to run |
| phase_o | output | 2 | 0 idle, 1 load config, 2 route, 3 execute |
| done_o | output | 1 | One-cycle end-of-run flag |
| rd_idx | input | 3 | Readout cell select |
| rd_reg1 | output | 16 | reg1 of selected cell |
| rd_reg2 | output | 16 | reg2 of selected cell |

## Verification
A configuration write can land in the same cycle that the shadow words are copied into the active set. A data load can arrive on that same edge, when it must be refused. A directed two-step run drives both strobes during the first load-configuration cycle, and drives a stray start pulse a cycle later. The bench model then runs step one with the old configuration and step two with the new one, and leaves the loaded value out. It compares every cell's results and the phase sequence against that model. Seeded random runs add arbitrary routing, operations and constants.

// File: rtl/mac_array_reconf.sv
module mac_array_reconf #(
  parameter int CELLS = 8,
  parameter int DW    = 16,
  parameter int SW    = 4,
  localparam int AW   = $clog2(CELLS),
  localparam int HW   = DW / 2,
  localparam int CW   = DW + 4 + 2 * AW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [AW-1:0] cfg_idx,
  input  logic [CW-1:0] cfg_word,
  input  logic          ld_we,
  input  logic [AW-1:0] ld_idx,
  input  logic [DW-1:0] ld_data,
  input  logic          start,
  input  logic [SW-1:0] steps,
  output logic [1:0]    phase_o,
  output logic          done_o,
  input  logic [AW-1:0] rd_idx,
  output logic [DW-1:0] rd_reg1,
  output logic [DW-1:0] rd_reg2
);

  typedef enum logic [1:0] {PH_IDLE, PH_CFG, PH_ROUTE, PH_EXEC} phase_t;

  phase_t ph;
  logic [SW-1:0] left;
  logic [CELLS-1:0][CW-1:0] shadow, active;
  logic [CELLS-1:0][DW-1:0] port1, port2, reg1, reg2, x1, x2;
  logic [CELLS-1:0][AW-1:0] src1, src2;

  function automatic logic [DW-1:0] alu(input logic [1:0] op, input logic [DW-1:0] a, input logic [DW-1:0] b);
    logic signed [HW-1:0] ar, ai, br, bi;
    logic signed [2*HW:0] pr, pi;
    ar = a[DW-1:HW]; ai = a[HW-1:0];
    br = b[DW-1:HW]; bi = b[HW-1:0];
    pr = ar * br - ai * bi;
    pi = ar * bi + ai * br;
    case (op)
      2'd0:    alu = {a[DW-1:HW] + b[DW-1:HW], a[HW-1:0] + b[HW-1:0]};
      2'd1:    alu = {pr[2*HW-2:HW-1], pi[2*HW-2:HW-1]};
      2'd2:    alu = a & b;
      default: alu = a;
    endcase
  endfunction

  for (genvar i = 0; i < CELLS; i++) begin : g_cell
    assign src1[i] = active[i][CW-1 -: AW];
    assign src2[i] = active[i][CW-1-AW -: AW];
    assign x1[i]   = alu(active[i][DW+3:DW+2], port1[i], port2[i]);
    assign x2[i]   = alu(active[i][DW+1:DW], x1[i], active[i][DW-1:0]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph <= PH_IDLE; left <= '0; done_o <= 1'b0;
      shadow <= '0; active <= '0;
      port1 <= '0; port2 <= '0; reg1 <= '0; reg2 <= '0;
    end else begin
      done_o <= 1'b0;
      if (cfg_we) shadow[cfg_idx] <= cfg_word;
      case (ph)
        PH_IDLE: begin
          if (ld_we) reg2[ld_idx] <= ld_data;
          if (start && steps != '0) begin
            left <= steps;
            ph   <= PH_CFG;
          end
        end
        PH_CFG: begin
          active <= shadow;
          ph     <= PH_ROUTE;
        end
        PH_ROUTE: begin
          for (int c = 0; c < CELLS; c++) begin
            port1[c] <= reg2[src1[c]];
            port2[c] <= reg2[src2[c]];
          end
          ph <= PH_EXEC;
        end
        default: begin
          reg1 <= x1;
          reg2 <= x2;
          if (left == 1) begin
            ph <= PH_IDLE; done_o <= 1'b1;
          end else begin
            left <= left - 1'b1;
            ph <= PH_CFG;
          end
        end
      endcase
    end
  end

  assign phase_o = ph;
  assign rd_reg1 = reg1[rd_idx];
  assign rd_reg2 = reg2[rd_idx];

  p_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_IDLE && start && steps != '0) |=> ph == PH_CFG);
  p_cfg_then_route_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ph == PH_CFG |=> ph == PH_ROUTE);
  p_route_then_exec_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ph == PH_ROUTE |=> ph == PH_EXEC);
  p_done_after_exec_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $past(ph) == PH_EXEC);
  p_done_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  p_active_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ph != PH_CFG |=> $stable(active));
  p_ports_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ph != PH_ROUTE |=> ($stable(port1) && $stable(port2)));
  p_reg1_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ph != PH_EXEC |=> $stable(reg1));
  p_run_no_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_CFG || ph == PH_ROUTE) |=> $stable(reg2));

endmodule

// File: tb/tb_mac_array_reconf.sv
module tb_mac_array_reconf;
  localparam int CLK_NS = 10;
  localparam int N = 8;

  logic clk = 0, rst_n = 0;
  logic cfg_we = 0, ld_we = 0, start = 0;
  logic [2:0] cfg_idx = 0, ld_idx = 0, rd_idx = 0;
  logic [25:0] cfg_word = 0;
  logic [15:0] ld_data = 0;
  logic [3:0] steps = 0;
  logic [1:0] phase_o;
  logic done_o;
  logic [15:0] rd_reg1, rd_reg2;

  int checks = 0, fails = 0;
  logic [25:0] m_sh [N];
  logic [25:0] m_act [N];
  logic [15:0] m_r1 [N], m_r2 [N], m_p1 [N], m_p2 [N];

  mac_array_reconf dut (.clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_word(cfg_word), .ld_we(ld_we), .ld_idx(ld_idx), .ld_data(ld_data),
    .start(start), .steps(steps), .phase_o(phase_o), .done_o(done_o),
    .rd_idx(rd_idx), .rd_reg1(rd_reg1), .rd_reg2(rd_reg2));

  always #(CLK_NS/2) clk = ~clk;

  function automatic logic [15:0] ref_op(input logic [1:0] op, input logic [15:0] a, input logic [15:0] b);
    int re, im;
    logic [7:0] s1, s0;
    re = ($signed(a[15:8]) * $signed(b[15:8]) - $signed(a[7:0]) * $signed(b[7:0])) >>> 7;
    im = ($signed(a[15:8]) * $signed(b[7:0]) + $signed(a[7:0]) * $signed(b[15:8])) >>> 7;
    s1 = a[15:8] + b[15:8];
    s0 = a[7:0] + b[7:0];
    case (op)
      0: return {s1, s0};
      1: return {re[7:0], im[7:0]};
      2: return a & b;
      default: return a;
    endcase
  endfunction

  function automatic logic [25:0] mk(input int s1, input int s2, input int o1, input int o2, input logic [15:0] k);
    logic [2:0] a = s1[2:0];
    logic [2:0] b = s2[2:0];
    logic [1:0] c = o1[1:0];
    logic [1:0] d = o2[1:0];
    return {a, b, c, d, k};
  endfunction

  task automatic m_step();
    logic [15:0] t2 [N];
    for (int c = 0; c < N; c++) begin m_act[c] = m_sh[c]; t2[c] = m_r2[c]; end
    for (int c = 0; c < N; c++) begin
      m_p1[c] = t2[m_act[c][25:23]];
      m_p2[c] = t2[m_act[c][22:20]];
      m_r1[c] = ref_op(m_act[c][19:18], m_p1[c], m_p2[c]);
      m_r2[c] = ref_op(m_act[c][17:16], m_r1[c], m_act[c][15:0]);
    end
  endtask

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cfg(input int c, input logic [25:0] w);
    @(negedge clk); cfg_we = 1; cfg_idx = c[2:0]; cfg_word = w;
    @(negedge clk); cfg_we = 0;
    m_sh[c] = w;
  endtask

  task automatic load(input int c, input logic [15:0] v);
    @(negedge clk); ld_we = 1; ld_idx = c[2:0]; ld_data = v;
    @(negedge clk); ld_we = 0;
    m_r2[c] = v;
  endtask

  task automatic compare_all(input string tag);
    for (int c = 0; c < N; c++) begin
      rd_idx = c[2:0]; #1;
      chk({tag, " R6 reg1"}, rd_reg1, m_r1[c]);
      chk({tag, " R7 reg2"}, rd_reg2, m_r2[c]);
    end
  endtask

  task automatic run(input int n);
    int k;
    @(negedge clk); start = 1; steps = n[3:0];
    @(negedge clk); start = 0;
    k = 0;
    while (!done_o && k < 200) begin @(negedge clk); k++; end
    chk("R3 done seen", {15'd0, done_o}, 16'd1);
    for (int s = 0; s < n; s++) m_step();
  endtask

  initial begin
    #(CLK_NS * 150000);
    fails++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    for (int c = 0; c < N; c++) begin
      m_sh[c] = 0; m_act[c] = 0; m_r1[c] = 0; m_r2[c] = 0; m_p1[c] = 0; m_p2[c] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 phase", {14'd0, phase_o}, 16'd0);
    chk("R1 done", {15'd0, done_o}, 16'd0);
    compare_all("R1 R11");

    @(negedge clk); start = 1; steps = 0;
    @(negedge clk); start = 0;
    chk("R2 zero steps ignored", {14'd0, phase_o}, 16'd0);

    // Directed: R8 corner operands, R5 routing
    load(0, 16'h8080); load(1, 16'h4000); load(2, 16'hF00F); load(3, 16'h7F01);
    cfg(0, mk(0, 0, 1, 3, 16'h0)); // (-1)*(-1) wraps
    cfg(1, mk(1, 3, 0, 2, 16'h0FF0));
    cfg(2, mk(2, 3, 2, 1, 16'h4000));
    cfg(3, mk(3, 1, 3, 0, 16'h0101));
    run(1);
    compare_all("R8 R5");

    // R9: config write while idle keeps results
    begin
      logic [15:0] keep1, keep2;
      rd_idx = 1; #1; keep1 = rd_reg1; keep2 = rd_reg2;
      cfg(1, mk(7, 7, 1, 1, 16'h1234));
      rd_idx = 1; #1;
      chk("R9 reg1 kept", rd_reg1, keep1);
      chk("R9 reg2 kept", rd_reg2, keep2);
    end

    // Directed collision run: R4 R10 R2 R3
    for (int c = 0; c < N; c++) begin
      cfg(c, mk(3, c, 0, 1, 16'h4000));
      load(c, 16'h1000 + c[15:0]);
    end
    @(negedge clk); start = 1; steps = 2;
    @(negedge clk); start = 0;
    chk("R2 phase cfg", {14'd0, phase_o}, 16'd1);
    cfg_we = 1; cfg_idx = 0; cfg_word = mk(5, 6, 2, 3, 16'h0);
    ld_we = 1; ld_idx = 3; ld_data = 16'h7777;
    @(negedge clk); cfg_we = 0; ld_we = 0;
    chk("R2 phase route", {14'd0, phase_o}, 16'd2);
    start = 1; steps = 5;
    @(negedge clk); start = 0;
    chk("R2 phase exec", {14'd0, phase_o}, 16'd3);
    @(negedge clk); chk("R2 phase cfg2", {14'd0, phase_o}, 16'd1);
    @(negedge clk); chk("R2 phase route2", {14'd0, phase_o}, 16'd2);
    @(negedge clk); chk("R2 phase exec2", {14'd0, phase_o}, 16'd3);
    chk("R3 done low before end", {15'd0, done_o}, 16'd0);
    @(negedge clk);
    chk("R3 done pulse", {15'd0, done_o}, 16'd1);
    chk("R2 back to idle", {14'd0, phase_o}, 16'd0);
    @(negedge clk);
    chk("R3 done one cycle", {15'd0, done_o}, 16'd0);
    m_step();
    m_sh[0] = mk(5, 6, 2, 3, 16'h0);
    m_step();
    compare_all("R4 R10");

    // Random runs
    for (int it = 0; it < 40; it++) begin
      for (int c = 0; c < N; c++) begin
        if ($urandom_range(0, 1) == 1) load(c, 16'($urandom));
        if ($urandom_range(0, 2) != 0)
          cfg(c, mk($urandom_range(0, 7), $urandom_range(0, 7), $urandom_range(0, 3),
                    $urandom_range(0, 3), 16'($urandom)));
      end
      run($urandom_range(1, 3));
      compare_all("random R5 R6 R7 R8");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule